// File: doc/BRIEF.md
# Overtemperature Alert Controller

This block watches a stream of temperature conversion results and decides when an overtemperature alert line should be asserted. Each result is a 16-bit word. The upper twelve bits hold a two's-complement temperature, and the low four bits carry no meaning. The block compares each result against a programmable upper trip point and a lower release point.

A configuration byte selects the alert behaviour:

- **Level-following (comparator) behaviour.** The alert stays on from a high crossing until a low crossing.
- **Event-latching (interrupt) behaviour.** Each crossing raises the alert, and host activity clears it.
- **Output sense.** The active level of the alert line is selectable.
- **Fault queue depth.** This sets how many consecutive out-of-limit results are needed before a crossing counts.
- **Alert-response clearing.** In interrupt behaviour, an acknowledged alert-response cycle can also clear the alert.

The surrounding sensor logic supplies a strobe with each new result. It also supplies single-cycle strobes for a register read, a one-shot register write and an alert-response acknowledge, plus the shutdown level. The block drives the alert level and a flag telling which limit caused the last event. The pad driver and the serial bus engine sit outside.

Top module: `ot_alert_ctrl`

## Requirements
- R1: After reset the alert is inactive, so `alert_out` equals the inverse of `cfg[2]`. After reset `limit_flag` is 0 and interrupt behaviour is armed for a high crossing.
- R2: `cfg[2]` selects the sense of `alert_out`: 0 drives 0 when active, 1 drives 1 when active.
- R3: `cfg[4:3]` sets the consecutive-result count needed for a crossing: 00→1, 01→2, 10→4, 11→6. Any result that is not out of limit restarts that side's count.
- R4: With `cfg[1]`=0, a qualified result strictly above `lim_hi` makes the alert active. A qualified result strictly below `lim_hys` makes it inactive.
- R5: With `cfg[1]`=0, results between or equal to the limits, register reads and shutdown leave the alert unchanged.
- R6: With `cfg[1]`=1, a qualified high crossing makes the alert active, and any register read makes it inactive.
- R7: With `cfg[1]`=1, after a high event the next event is a qualified result below `lim_hys`, which also makes the alert active. High results before it do nothing. After a low event the next event needs a high crossing again.
- R8: With `cfg[1]`=1, asserting `shutdown` clears an active alert. With `cfg[1]`=0, `shutdown` has no effect.
- R9: With `cfg[1]`=1 and `cfg[7]`=1, `ara_ack` clears the alert. With `cfg[7]`=0, `ara_ack` is ignored.
- R10: With `cfg[1]`=0 and `cfg[5]`=1, `oneshot_wr` clears the alert if the most recent result was below `lim_hys`. Otherwise, or with `cfg[5]`=0, it is ignored.
- R11: `limit_flag` becomes 1 on a high event and 0 on a low event. It keeps its value otherwise, including across clears.
- R12: Comparisons are signed and use only bits 15:4 of the result and of both limits.
- R13: A new result's effect is visible on the outputs after the clock edge that samples its strobe. On the same edge, a result event overrides a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | New conversion result strobe |
| res_value | input | 16 | Conversion result, temperature in bits 15:4 |
| cfg | input | 8 | Configuration byte |
| lim_hi | input | 16 | Upper trip limit, bits 15:4 used |
| lim_hys | input | 16 | Lower release limit, bits 15:4 used |
| reg_rd | input | 1 | Any register read strobe |
| shutdown | input | 1 | Shutdown level |
| oneshot_wr | input | 1 | One-shot register write strobe |
| ara_ack | input | 1 | Acknowledged alert-response strobe |
| alert_out | output | 1 | Alert level after sense selection |
| limit_flag | output | 1 | 1 = last event was high, 0 = low |

## Verification
Results are driven in four patterns. Values just above and just below each limit separate the trips from the holds. Values exactly equal to a limit show that equality never trips. Runs of repeated out-of-limit results, broken by one in-range value, pin the queue depth and the count restart. Negative limits with positive temperatures, and words that differ only in the low nibble, expose unsigned comparisons or a compare that uses the wrong field. Each clear source is applied in both behaviours, so a clear that leaks into the wrong mode shows up.

// File: rtl/ot_alert_pkg.sv
// Package: shared constants and helpers for the overtemperature alert block.
// Assumes configuration bit positions are fixed by the register layout.
package ot_alert_pkg;
    localparam int REG_W      = 16;
    localparam int TEMP_LSB   = 4;
    localparam int QCNT_W     = 3;
    localparam int CFG_W      = 8;

    localparam int CFG_INTR    = 1;
    localparam int CFG_POL     = 2;
    localparam int CFG_QLO     = 3;
    localparam int CFG_QHI     = 4;
    localparam int CFG_ONESHOT = 5;
    localparam int CFG_SMBA    = 7;

    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;
    localparam int N_SIDES = 2;

    // Decode the two-bit queue selector into a consecutive-result count.
    function automatic logic [QCNT_W-1:0] depth_of(input logic [1:0] sel);
        case (sel)
            2'b00:   depth_of = QCNT_W'(1);
            2'b01:   depth_of = QCNT_W'(2);
            2'b10:   depth_of = QCNT_W'(4);
            default: depth_of = QCNT_W'(6);
        endcase
    endfunction
endpackage

// File: rtl/ot_limit_cmp.sv
// Module: signed comparison of a result word against both limits.
// Assumes the temperature field occupies bits REG_W-1:TEMP_LSB of all words.
module ot_limit_cmp #(
    parameter int REG_W    = 16,
    parameter int TEMP_LSB = 4
) (
    input  logic [REG_W-1:0] temp,
    input  logic [REG_W-1:0] hi,
    input  logic [REG_W-1:0] hys,
    output logic             above,
    output logic             below
);
    localparam int TW = REG_W - TEMP_LSB;

    logic signed [TW-1:0] t_s, hi_s, hys_s;

    // Extract the signed temperature fields and compare strictly.
    always_comb begin
        t_s   = $signed(temp[REG_W-1:TEMP_LSB]);
        hi_s  = $signed(hi[REG_W-1:TEMP_LSB]);
        hys_s = $signed(hys[REG_W-1:TEMP_LSB]);
        above = t_s > hi_s;
        below = t_s < hys_s;
    end
endmodule

// File: rtl/ot_fault_queue.sv
// Module: counts consecutive out-of-limit results for one side and reports
// when the programmed count is reached. Assumes depth is at least 1.
module ot_fault_queue #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             fault,
    input  logic [CNT_W-1:0] depth,
    output logic             trip
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt, cnt_inc;

    // Saturating next count and qualification of the current result.
    always_comb begin
        cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        trip    = sample && fault && (cnt_inc >= depth);
    end

    // Advance on a faulty result, restart on a clean one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (sample) cnt <= fault ? cnt_inc : '0;
    end
endmodule

// File: rtl/ot_alert_state.sv
// Module: alert state machine covering comparator and interrupt behaviour,
// all clear sources and the limit flag. Assumes trips are single-cycle.
module ot_alert_state (
    input  logic clk,
    input  logic rst_n,
    input  logic res_valid,
    input  logic below_raw,
    input  logic hot_trip,
    input  logic cold_trip,
    input  logic intr_mode,
    input  logic smba_en,
    input  logic oneshot_mode,
    input  logic reg_rd,
    input  logic shutdown,
    input  logic oneshot_wr,
    input  logic ara_ack,
    output logic active,
    output logic limit_flag
);
    logic armed_hi, last_below;
    logic set_hi, set_lo, cmp_clr, os_clr, int_clr;

    // Classify this cycle's events and clear requests.
    always_comb begin
        set_hi  = hot_trip && (!intr_mode || armed_hi);
        set_lo  = intr_mode && cold_trip && !armed_hi;
        cmp_clr = !intr_mode && cold_trip && !hot_trip;
        os_clr  = !intr_mode && oneshot_mode && oneshot_wr && last_below;
        int_clr = intr_mode && (reg_rd || shutdown || (smba_en && ara_ack));
    end

    // Alert level: events win over clears on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          active <= 1'b0;
        else if (set_hi || set_lo)           active <= 1'b1;
        else if (cmp_clr || os_clr || int_clr) active <= 1'b0;
    end

    // Interrupt arming: alternate between waiting for high and low crossings.
    always_ff @(posedge clk) begin
        if (!rst_n)                   armed_hi <= 1'b1;
        else if (intr_mode && set_hi) armed_hi <= 1'b0;
        else if (set_lo)              armed_hi <= 1'b1;
    end

    // Flag records which side produced the most recent event.
    always_ff @(posedge clk) begin
        if (!rst_n)                limit_flag <= 1'b0;
        else if (set_hi)           limit_flag <= 1'b1;
        else if (set_lo || cmp_clr) limit_flag <= 1'b0;
    end

    // Remember whether the latest result sat below the release limit.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_below <= 1'b0;
        else if (res_valid) last_below <= below_raw;
    end
endmodule

// File: rtl/ot_alert_ctrl.sv
// Module: top of the overtemperature alert block. Compares each result with
// both limits, qualifies crossings through per-side queues, runs the alert
// state and applies output sense. Assumes strobes are single-cycle pulses.
module ot_alert_ctrl
    import ot_alert_pkg::*;
#(
    parameter int P_REG_W    = REG_W,
    parameter int P_TEMP_LSB = TEMP_LSB,
    parameter int P_QCNT_W   = QCNT_W,
    parameter int P_CFG_W    = CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_valid,
    input  logic [P_REG_W-1:0] res_value,
    input  logic [P_CFG_W-1:0] cfg,
    input  logic [P_REG_W-1:0] lim_hi,
    input  logic [P_REG_W-1:0] lim_hys,
    input  logic               reg_rd,
    input  logic               shutdown,
    input  logic               oneshot_wr,
    input  logic               ara_ack,
    output logic               alert_out,
    output logic               limit_flag
);
    logic                above, below;
    logic [N_SIDES-1:0]  side_fault, side_trip;
    logic [P_QCNT_W-1:0] depth;
    logic                active;

    ot_limit_cmp #(.REG_W(P_REG_W), .TEMP_LSB(P_TEMP_LSB)) cmp_i (
        .temp  (res_value),
        .hi    (lim_hi),
        .hys   (lim_hys),
        .above (above),
        .below (below)
    );

    // Map each side to its raw fault and decode the queue depth.
    always_comb begin
        side_fault[SIDE_HI] = above;
        side_fault[SIDE_LO] = below;
        depth = P_QCNT_W'(depth_of(cfg[CFG_QHI:CFG_QLO]));
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        ot_fault_queue #(.CNT_W(P_QCNT_W)) q_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (res_valid),
            .fault  (side_fault[s]),
            .depth  (depth),
            .trip   (side_trip[s])
        );
    end

    ot_alert_state st_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .below_raw    (below),
        .hot_trip     (side_trip[SIDE_HI]),
        .cold_trip    (side_trip[SIDE_LO]),
        .intr_mode    (cfg[CFG_INTR]),
        .smba_en      (cfg[CFG_SMBA]),
        .oneshot_mode (cfg[CFG_ONESHOT]),
        .reg_rd       (reg_rd),
        .shutdown     (shutdown),
        .oneshot_wr   (oneshot_wr),
        .ara_ack      (ara_ack),
        .active       (active),
        .limit_flag   (limit_flag)
    );

    // Apply the selected output sense.
    always_comb alert_out = cfg[CFG_POL] ? active : !active;
endmodule

// File: rtl/ot_alert_chk.sv
// Module: assertion checker for ot_alert_ctrl, attached by bind.
// Works from the top-level ports only.
module ot_alert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        res_valid,
    input logic [7:0]  cfg,
    input logic        reg_rd,
    input logic        shutdown,
    input logic        oneshot_wr,
    input logic        ara_ack,
    input logic        alert_out,
    input logic        limit_flag
);
    logic lvl;
    // Asserted state seen at the pin, independent of sense.
    always_comb lvl = (alert_out == cfg[2]);

    // R1: reset leaves alert inactive and flag low
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!lvl && !limit_flag));

    // R5: comparator behaviour holds without results or a one-shot clear
    a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[1] && !res_valid && !(cfg[5] && oneshot_wr)) |=> $stable(lvl));

    // R6: a read clears interrupt behaviour
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1] && reg_rd && !res_valid) |=> !lvl);

    // R8: shutdown clears interrupt behaviour
    a_r8_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1] && shutdown && !res_valid) |=> !lvl);

    // R9: acknowledge ignored when alert-response clearing is off
    a_r9_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1] && !cfg[7] && ara_ack && !reg_rd && !shutdown && !res_valid)
        |=> $stable(lvl));

    // R11: flag moves only with a result
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(limit_flag));
endmodule

bind ot_alert_ctrl ot_alert_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .cfg        (cfg),
    .reg_rd     (reg_rd),
    .shutdown   (shutdown),
    .oneshot_wr (oneshot_wr),
    .ara_ack    (ara_ack),
    .alert_out  (alert_out),
    .limit_flag (limit_flag)
);

// File: tb/ot_alert_ctrl_tb_top.sv
// Bench: walks a vector table of operations with expected outputs, then
// directed tests for reset, signed limits and low-nibble masking.
module ot_alert_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_value = '0;
    logic [7:0]  cfg = '0;
    logic [15:0] lim_hi = 16'h5000;
    logic [15:0] lim_hys = 16'h4B00;
    logic        reg_rd = 1'b0, shutdown = 1'b0, oneshot_wr = 1'b0, ara_ack = 1'b0;
    logic        alert_out, limit_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ot_alert_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
        .cfg(cfg), .lim_hi(lim_hi), .lim_hys(lim_hys), .reg_rd(reg_rd),
        .shutdown(shutdown), .oneshot_wr(oneshot_wr), .ara_ack(ara_ack),
        .alert_out(alert_out), .limit_flag(limit_flag)
    );

    localparam logic [2:0] OP_RES = 3'd0, OP_RD = 3'd1, OP_SHDN = 3'd2,
                           OP_OSW = 3'd3, OP_ARA = 3'd4;
    // Temperatures: 81C, 80C, 76C, 75C, 74C
    localparam logic [15:0] TH = 16'h5100, TE = 16'h5000, TM = 16'h4C00,
                            TY = 16'h4B00, TL = 16'h4A00;
    localparam int NV = 46;
    // {req, op, cfg, value, expected alert_out, expected limit_flag}
    localparam logic [32:0] VEC [NV] = '{
        {4'd4,  OP_RES,  8'h00, TM, 1'b1, 1'b0},  // R4 between limits
        {4'd4,  OP_RES,  8'h00, TE, 1'b1, 1'b0},  // R4 equal high no trip
        {4'd4,  OP_RES,  8'h00, TH, 1'b0, 1'b1},  // R4 trip high
        {4'd5,  OP_RES,  8'h00, TM, 1'b0, 1'b1},  // R5 hold
        {4'd5,  OP_RES,  8'h00, TY, 1'b0, 1'b1},  // R5 equal release holds
        {4'd8,  OP_SHDN, 8'h00, TY, 1'b0, 1'b1},  // R8 shutdown no effect
        {4'd5,  OP_RD,   8'h00, TY, 1'b0, 1'b1},  // R5 read no effect
        {4'd4,  OP_RES,  8'h00, TL, 1'b1, 1'b0},  // R4 release
        {4'd2,  OP_RES,  8'h04, TH, 1'b1, 1'b1},  // R2 active high
        {4'd2,  OP_RES,  8'h04, TL, 1'b0, 1'b0},  // R2 inactive low
        {4'd3,  OP_RES,  8'h08, TH, 1'b1, 1'b0},  // R3 depth2 first
        {4'd3,  OP_RES,  8'h08, TM, 1'b1, 1'b0},  // R3 restart
        {4'd3,  OP_RES,  8'h08, TH, 1'b1, 1'b0},  // R3 one again
        {4'd3,  OP_RES,  8'h08, TH, 1'b0, 1'b1},  // R3 second trips
        {4'd3,  OP_RES,  8'h08, TL, 1'b0, 1'b1},  // R3 cold first
        {4'd3,  OP_RES,  8'h08, TL, 1'b1, 1'b0},  // R3 cold second
        {4'd3,  OP_RES,  8'h18, TH, 1'b1, 1'b0},  // R3 depth6 1
        {4'd3,  OP_RES,  8'h18, TH, 1'b1, 1'b0},  // R3 2
        {4'd3,  OP_RES,  8'h18, TH, 1'b1, 1'b0},  // R3 3
        {4'd3,  OP_RES,  8'h18, TH, 1'b1, 1'b0},  // R3 4
        {4'd3,  OP_RES,  8'h18, TH, 1'b1, 1'b0},  // R3 5
        {4'd3,  OP_RES,  8'h18, TH, 1'b0, 1'b1},  // R3 6 trips
        {4'd4,  OP_RES,  8'h00, TL, 1'b1, 1'b0},  // R4 release depth1
        {4'd6,  OP_RES,  8'h02, TH, 1'b0, 1'b1},  // R6 interrupt set
        {4'd6,  OP_RD,   8'h02, TH, 1'b1, 1'b1},  // R6 read clears
        {4'd7,  OP_RES,  8'h02, TH, 1'b1, 1'b1},  // R7 no retrigger
        {4'd7,  OP_RES,  8'h02, TM, 1'b1, 1'b1},  // R7 between
        {4'd7,  OP_RES,  8'h02, TL, 1'b0, 1'b0},  // R7 low event
        {4'd6,  OP_RD,   8'h02, TL, 1'b1, 1'b0},  // R6 read clears
        {4'd7,  OP_RES,  8'h02, TL, 1'b1, 1'b0},  // R7 low no retrigger
        {4'd7,  OP_RES,  8'h02, TH, 1'b0, 1'b1},  // R7 rearmed high
        {4'd8,  OP_SHDN, 8'h02, TH, 1'b1, 1'b1},  // R8 shutdown clears
        {4'd7,  OP_RES,  8'h02, TL, 1'b0, 1'b0},  // R7 low event
        {4'd9,  OP_ARA,  8'h02, TL, 1'b0, 1'b0},  // R9 ack ignored
        {4'd9,  OP_ARA,  8'h82, TL, 1'b1, 1'b0},  // R9 ack clears
        {4'd11, OP_RES,  8'h82, TH, 1'b0, 1'b1},  // R11 high flag
        {4'd11, OP_RD,   8'h82, TH, 1'b1, 1'b1},  // R11 flag kept on clear
        {4'd10, OP_RES,  8'h20, TH, 1'b0, 1'b1},  // R10 set in one-shot
        {4'd10, OP_OSW,  8'h20, TH, 1'b0, 1'b1},  // R10 not below, ignored
        {4'd10, OP_RES,  8'h28, TL, 1'b0, 1'b1},  // R10 below, unqualified
        {4'd10, OP_OSW,  8'h28, TL, 1'b1, 1'b1},  // R10 one-shot clears
        {4'd3,  OP_RES,  8'h08, TH, 1'b1, 1'b1},  // R3 first
        {4'd3,  OP_RES,  8'h08, TH, 1'b0, 1'b1},  // R3 second
        {4'd10, OP_RES,  8'h08, TL, 1'b0, 1'b1},  // R10 below, unqualified
        {4'd10, OP_OSW,  8'h08, TL, 1'b0, 1'b1},  // R10 not one-shot, ignored
        {4'd4,  OP_RES,  8'h00, TL, 1'b1, 1'b0}   // R4 release
    };

    // Compare both outputs with expectations for a requirement.
    task automatic check(input int req, input logic ea, input logic ef);
        checks++;
        if (alert_out !== ea || limit_flag !== ef) begin
            errors++;
            $display("FAIL R%0d: alert_out=%b limit_flag=%b expected %b %b",
                     req, alert_out, limit_flag, ea, ef);
        end
    endtask

    // Drive one operation for one cycle; outputs settle after the next edge.
    task automatic apply(input logic [2:0] op, input logic [7:0] c, input logic [15:0] v);
        @(negedge clk);
        cfg        = c;
        res_value  = v;
        res_valid  = (op == OP_RES);
        reg_rd     = (op == OP_RD);
        shutdown   = (op == OP_SHDN);
        oneshot_wr = (op == OP_OSW);
        ara_ack    = (op == OP_ARA);
        @(negedge clk);
        res_valid = 1'b0; reg_rd = 1'b0; shutdown = 1'b0;
        oneshot_wr = 1'b0; ara_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, 1'b1, 1'b0);  // R1 reset state, active-low sense

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][28:26], VEC[i][25:18], VEC[i][17:2]);
            check(int'(VEC[i][32:29]), VEC[i][1], VEC[i][0]);
        end

        // R13 result event wins over a same-edge read in interrupt behaviour
        apply(OP_RES, 8'h02, TH);  // armed high after reset? no: armed low now
        @(negedge clk);
        cfg = 8'h02; res_value = TL; res_valid = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; reg_rd = 1'b0;
        check(13, 1'b0, 1'b0);

        // R1 mid-run reset from an active state, re-armed for a high crossing
        do_reset();
        check(1, 1'b1, 1'b0);
        apply(OP_RES, 8'h02, TH);
        check(1, 1'b0, 1'b1);

        // R12 signed limits: -10C high, -20C release
        do_reset();
        lim_hi = 16'hF600; lim_hys = 16'hEC00;
        apply(OP_RES, 8'h00, 16'h0100);  // +1C above -10C
        check(12, 1'b0, 1'b1);
        apply(OP_RES, 8'h00, 16'hE200);  // -30C below -20C
        check(12, 1'b1, 1'b0);
        // R12 low nibble ignored
        lim_hi = 16'h5000; lim_hys = 16'h4B00;
        apply(OP_RES, 8'h00, 16'h500F);
        check(12, 1'b1, 1'b0);
        apply(OP_RES, 8'h00, 16'h5010);
        check(12, 1'b0, 1'b1);
        apply(OP_RES, 8'h00, 16'h4B0F);
        check(12, 1'b0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule